// File: doc/BRIEF.md
# Delayed Pulse Timer

A one-shot timer that waits for an edge on one of several trigger lines, counts a programmable delay, and then drives an active output for a programmable number of clock cycles. When the active window closes it raises a single-cycle end event and parks in a completed state until it is reset. The trigger line is picked by a select input, and a polarity input sets which edge of that line starts the timer.

A synchronous timer reset returns the block to idle from any state and aborts a window in progress without raising an end event. From idle the timer moves on its own to the waiting-for-trigger state one cycle later. Delay and duration are counts of clock cycles. All inputs are taken to be synchronous to the clock.

States and transitions: IDLE (code 0) always goes to WAIT (code 1). WAIT goes on a qualifying edge to DELAY (code 2) when the delay is nonzero, else to ACTIVE (code 3) when the duration is nonzero, else to DONE (code 4). DELAY goes, when its count runs out, to ACTIVE, or to DONE if the duration is zero. ACTIVE goes to DONE when its count runs out. DONE holds. The timer reset forces IDLE from every state.

Top module: `dly_pulse_timer`

## Requirements
- R1: Only the line chosen by `sel_i` (index into `src_i`) can start the timer. Edges on the other lines leave the status at WAIT (code 1).
- R2: With `pol_i`=0 a low-to-high change of the chosen line starts the timer. With `pol_i`=1 a high-to-low change starts it. The opposite change has no effect.
- R3: If the starting edge is seen at clock edge P0, `active_o` is first high after edge P0+D, where D is `delay_i` as captured at P0. With D=0 the output is high in the cycle right after P0. While D cycles elapse, `status_o` reads 2.
- R4: `active_o` stays high for exactly N cycles, where N is `dur_i` as captured when the active phase begins. While it is high, `status_o` reads 3.
- R5: `end_o` is high for exactly one cycle, after edge P0+D+N, and never together with `active_o`. With N=0 it fires after edge P0+D and `active_o` never rises.
- R6: `status_o` codes are IDLE=0, WAIT=1, DELAY=2, ACTIVE=3, DONE=4. IDLE lasts one cycle and is followed by WAIT. DONE holds until a timer reset.
- R7: Qualifying edges that arrive in DELAY, ACTIVE or DONE are ignored. The timing of the run in progress is unchanged.
- R8: `timer_rst` high at a clock edge puts the block in IDLE with `active_o` and `end_o` low after that edge, and no end event is raised for an aborted window. `rst_n` low gives the same reset state asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_rst | input | 1 | Synchronous timer reset / abort |
| src_i | input | NUM_SRC | Trigger lines |
| sel_i | input | $clog2(NUM_SRC) | Index of the trigger line used |
| pol_i | input | 1 | 0: start on rising change, 1: start on falling change |
| delay_i | input | CNT_W | Pre-start delay in cycles |
| dur_i | input | CNT_W | Active duration in cycles |
| active_o | output | 1 | High during the active window |
| end_o | output | 1 | One-cycle end event |
| status_o | output | 3 | State code (0 to 4) |

## Verification
A wrong state shows on `status_o` at the very next sample, because the code is brought straight out. A wrong counter value shows as an active window that opens or closes early or late. It also shows as an end event in the wrong cycle, compared against P0+D and P0+D+N. The bench sweeps every delay and duration from 0 to 4 over every line and both polarities. Each run includes wrong-edge and other-line distractors before the start and a second edge mid-run, so mistakes in edge detection or in ignoring triggers appear within one or two cycles as a premature leave from WAIT or a shifted window.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_DELAY  = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_DONE   = 3'd4
    } tmr_state_e;
endpackage

// File: rtl/dpt_trig_sel.sv
module dpt_trig_sel #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               pol_i,
    output logic               edge_o
);
    logic lvl;
    logic lvl_q;

    // Normalise the chosen line so that a start is always a rising change.
    always_comb begin
        lvl = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(i)) lvl = src_i[i] ^ pol_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign edge_o = lvl & ~lvl_q;
endmodule

// File: rtl/dpt_down_cnt.sv
module dpt_down_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dly_pulse_timer.sv
module dly_pulse_timer
    import dpt_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int CNT_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       timer_rst,
    input  logic [NUM_SRC-1:0]         src_i,
    input  logic [$clog2(NUM_SRC)-1:0] sel_i,
    input  logic                       pol_i,
    input  logic [CNT_W-1:0]           delay_i,
    input  logic [CNT_W-1:0]           dur_i,
    output logic                       active_o,
    output logic                       end_o,
    output logic [2:0]                 status_o
);
    localparam int SEL_W = $clog2(NUM_SRC);

    tmr_state_e       state_q, state_d;
    logic             trig;
    logic             cnt_zero;
    logic             cnt_load;
    logic             cnt_dec;
    logic [CNT_W-1:0] cnt_val;
    logic             active_q;
    logic             end_q;

    dpt_trig_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .sel_i  (sel_i),
        .pol_i  (pol_i),
        .edge_o (trig)
    );

    dpt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    // Next state and counter control.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE:   state_d = ST_WAIT;
            ST_WAIT: begin
                if (trig) begin
                    if (delay_i != '0) begin
                        state_d  = ST_DELAY;
                        cnt_load = 1'b1;
                        cnt_val  = delay_i - 1'b1;
                    end else if (dur_i != '0) begin
                        state_d  = ST_ACTIVE;
                        cnt_load = 1'b1;
                        cnt_val  = dur_i - 1'b1;
                    end else begin
                        state_d  = ST_DONE;
                    end
                end
            end
            ST_DELAY: begin
                if (cnt_zero) begin
                    if (dur_i != '0) begin
                        state_d  = ST_ACTIVE;
                        cnt_load = 1'b1;
                        cnt_val  = dur_i - 1'b1;
                    end else begin
                        state_d  = ST_DONE;
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (cnt_zero) state_d = ST_DONE;
                else          cnt_dec = 1'b1;
            end
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
        if (timer_rst) begin
            state_d  = ST_IDLE;
            cnt_load = 1'b0;
            cnt_dec  = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            end_q    <= 1'b0;
        end else begin
            active_q <= (state_d == ST_ACTIVE);
            end_q    <= (state_d == ST_DONE) && (state_q != ST_DONE);
        end
    end

    assign active_o = active_q;
    assign end_o    = end_q;
    assign status_o = state_q;
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       timer_rst,
    input logic       active_o,
    input logic       end_o,
    input logic [2:0] status_o
);
    AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        status_o <= 3'd4);                                                   // R6
    AST_IDLE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'd0 && !timer_rst) |=> status_o == 3'd1);              // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'd4 && !timer_rst) |=> (status_o == 3'd4 && !end_o));  // R6
    AST_ACT_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> status_o == 3'd3);                                      // R4
    AST_END_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |-> (status_o == 3'd4 && !active_o));                          // R5
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> !end_o);                                                   // R5
    AST_FALL_GIVES_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active_o) && !$past(timer_rst)) |-> end_o);                   // R5
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        timer_rst |=> (status_o == 3'd0 && !active_o && !end_o));            // R8
endmodule

bind dly_pulse_timer dpt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_rst (timer_rst),
    .active_o  (active_o),
    .end_o     (end_o),
    .status_o  (status_o)
);

// File: tb/dly_pulse_timer_tb.sv
module dly_pulse_timer_tb;
    localparam int NS = 4;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          timer_rst = 1'b1;
    logic [NS-1:0] src = '0;
    logic [1:0]    sel = '0;
    logic          pol = 1'b0;
    logic [CW-1:0] dly = '0;
    logic [CW-1:0] dur = '0;
    logic          active;
    logic          endp;
    logic [2:0]    status;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dly_pulse_timer #(.NUM_SRC(NS), .CNT_W(CW)) u_dut (
        .clk (clk), .rst_n (rst_n), .timer_rst (timer_rst),
        .src_i (src), .sel_i (sel), .pol_i (pol),
        .delay_i (dly), .dur_i (dur),
        .active_o (active), .end_o (endp), .status_o (status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (s=%0d p=%0d d=%0d n=%0d)",
                     req, act, exp, sel, pol, dly, dur);
        end
    endtask

    task automatic run_case(input int s, input int p, input int d, input int n);
        logic [NS-1:0] others;
        others = ~(NS'(1) << s);
        @(negedge clk);
        sel = 2'(s); pol = p[0]; dly = d; dur = n;
        src = {NS{~p[0]}};             // chosen line held at its post-edge level
        timer_rst = 1'b1;
        @(negedge clk);
        timer_rst = 1'b0;
        chk("R8 idle after timer reset", int'(status), 0);
        @(negedge clk);
        chk("R6 idle then wait", int'(status), 1);
        src[s] = p[0];                 // wrong-direction change
        @(negedge clk);
        chk("R2 opposite edge ignored", int'(status), 1);
        src = src ^ others;
        @(negedge clk);
        chk("R1 other lines ignored", int'(status), 1);
        src = src ^ others;            // other lines now make a starting-direction change
        @(negedge clk);
        chk("R1 other lines ignored", int'(status), 1);
        src[s] = ~p[0];                // the real start, seen at edge P0
        for (int k = 0; k <= d + n + 2; k++) begin
            @(negedge clk);
            chk("R3 R4 active window", int'(active), int'((k >= d) && (k < d + n)));
            chk("R5 end pulse", int'(endp), int'(k == d + n));
            chk("R6 state code", int'(status), (k < d) ? 2 : ((k < d + n) ? 3 : 4));
            if (k == 0) src[s] = p[0];
            if (k == 1) src[s] = ~p[0]; // R7: second start edge mid-run
        end
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog actual=hang expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #5;
        chk("R8 reset status", int'(status), 0);
        chk("R8 reset active", int'(active), 0);
        chk("R8 reset end", int'(endp), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 2; p++)
                for (int d = 0; d <= 4; d++)
                    for (int n = 0; n <= 4; n++)
                        run_case(s, p, d, n);

        // R8: abort in the middle of the active window
        @(negedge clk);
        sel = 2'd1; pol = 1'b0; dly = 2; dur = 6; src = '0; timer_rst = 1'b1;
        @(negedge clk); timer_rst = 1'b0;
        @(negedge clk); src[1] = 1'b1;
        for (int k = 0; k <= 4; k++) @(negedge clk);
        chk("R4 active before abort", int'(active), 1);
        timer_rst = 1'b1;
        @(negedge clk);
        timer_rst = 1'b0;
        chk("R8 abort status", int'(status), 0);
        chk("R8 abort active", int'(active), 0);
        chk("R8 abort no end", int'(endp), 0);
        @(negedge clk);
        chk("R8 abort end stays low", int'(endp), 0);
        chk("R6 wait after abort", int'(status), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule